// File: doc/BRIEF.md
# Register Source and Destination Selector

This block holds the decode and write-back register control for a single-cycle 64-bit processor. It takes the instruction class code, the two register fields of the instruction and the condition result from the execute stage. From these it derives four register identifiers: two read selectors and two write selectors. One write selector is for the ALU result and one is for the memory result. The same block holds the 15-entry general register bank, with two read ports and two write ports.

The identifier value 15 (all ones) means "no register". A read through it returns zero, and a write through it is dropped. Stack instructions name the stack pointer (identifier 4) without taking it from the instruction fields. A conditional move whose condition is false is cancelled: its ALU-result destination is forced to the null identifier.

Reads are combinational from the current bank contents. Both writes take effect at the rising clock edge. Reset is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `regsel_top`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero until it is written.
- R2: Class codes: 6 (ALU op) reads ra and rb and writes ALU result to rb. 4 (store) reads ra and rb with no writes. 5 (load) reads rb and writes the memory result to ra. 3 (immediate) reads nothing and writes the ALU result to rb.
- R3: With SP = 4: 8 (call) reads SP on src_b and writes SP from the ALU. 9 (return) reads SP on both ports and writes SP from the ALU. 10 (push) reads ra and SP and writes SP from the ALU. 11 (pop) reads SP on both ports, writes SP from the ALU and writes ra from memory.
- R4: Class 2 (conditional move) reads ra on src_a and 15 on src_b. dst_e is rb when cnd is 1 and 15 when cnd is 0, and a cancelled move leaves rb unchanged.
- R5: Classes 0, 1, 7 and 12 to 15 produce 15 on all four identifier outputs.
- R6: A read port whose identifier is 15 returns zero.
- R7: At the rising edge, the register named by dst_e takes val_e and the register named by dst_m takes val_m. An identifier of 15 writes nothing.
- R8: When dst_e and dst_m name the same register, that register takes val_m.
- R9: cnd has no effect on any identifier for classes other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icode | input | 4 | Instruction class code |
| ra | input | 4 | First register field |
| rb | input | 4 | Second register field |
| cnd | input | 1 | Condition result from execute |
| val_e | input | 64 | ALU result to write back |
| val_m | input | 64 | Memory result to write back |
| src_a | output | 4 | Read selector A |
| src_b | output | 4 | Read selector B |
| dst_e | output | 4 | Write selector for ALU result |
| dst_m | output | 4 | Write selector for memory result |
| rd_a | output | 64 | Data read through src_a |
| rd_b | output | 64 | Data read through src_b |

## Verification
The four identifiers and both read data outputs are combinational, so they are due in the same cycle as the inputs. The bench drives at the falling edge and samples a nanosecond later. A write appears one rising edge after its cycle, so the bench reads a register back in the cycle that follows that edge. Reset clears the bank at once, while release takes two rising edges through the synchronizer, and the bench waits three edges before it issues the first instruction.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  localparam int ID_W = 4;
  localparam logic [ID_W-1:0] ID_NONE = '1;

  localparam logic [3:0] OP_HALT = 4'h0;
  localparam logic [3:0] OP_NOP  = 4'h1;
  localparam logic [3:0] OP_MOVC = 4'h2;
  localparam logic [3:0] OP_IMMV = 4'h3;
  localparam logic [3:0] OP_STOR = 4'h4;
  localparam logic [3:0] OP_LOAD = 4'h5;
  localparam logic [3:0] OP_ALU  = 4'h6;
  localparam logic [3:0] OP_JUMP = 4'h7;
  localparam logic [3:0] OP_CALL = 4'h8;
  localparam logic [3:0] OP_RET  = 4'h9;
  localparam logic [3:0] OP_PUSH = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;

  typedef struct packed {
    logic [ID_W-1:0] src_a;
    logic [ID_W-1:0] src_b;
    logic [ID_W-1:0] dst_e;
    logic [ID_W-1:0] dst_m;
  } regids_t;
endpackage

// File: rtl/regsel_rst_sync.sv
module regsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/regsel_id_decode.sv
module regsel_id_decode
  import regsel_pkg::*;
#(
  parameter logic [ID_W-1:0] SP_ID = 4'd4
) (
  input  logic [3:0]      icode,
  input  logic [ID_W-1:0] ra,
  input  logic [ID_W-1:0] rb,
  input  logic            cnd,
  output regids_t         ids
);
  always_comb begin
    ids = '{src_a: ID_NONE, src_b: ID_NONE, dst_e: ID_NONE, dst_m: ID_NONE};
    unique case (icode)
      OP_MOVC: begin
        ids.src_a = ra;
        ids.dst_e = cnd ? rb : ID_NONE;
      end
      OP_IMMV: ids.dst_e = rb;
      OP_STOR: begin
        ids.src_a = ra;
        ids.src_b = rb;
      end
      OP_LOAD: begin
        ids.src_b = rb;
        ids.dst_m = ra;
      end
      OP_ALU: begin
        ids.src_a = ra;
        ids.src_b = rb;
        ids.dst_e = rb;
      end
      OP_CALL: begin
        ids.src_b = SP_ID;
        ids.dst_e = SP_ID;
      end
      OP_RET: begin
        ids.src_a = SP_ID;
        ids.src_b = SP_ID;
        ids.dst_e = SP_ID;
      end
      OP_PUSH: begin
        ids.src_a = ra;
        ids.src_b = SP_ID;
        ids.dst_e = SP_ID;
      end
      OP_POP: begin
        ids.src_a = SP_ID;
        ids.src_b = SP_ID;
        ids.dst_e = SP_ID;
        ids.dst_m = ra;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regsel_bank.sv
module regsel_bank
  import regsel_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id_a,
  input  logic [ID_W-1:0] id_b,
  input  logic [ID_W-1:0] id_e,
  input  logic [ID_W-1:0] id_m,
  input  logic [XLEN-1:0] val_e,
  input  logic [XLEN-1:0] val_m,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] rf [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic            hit_e, hit_m, wen;
    logic [XLEN-1:0] d, q;
    always_comb begin
      hit_e = (int'(id_e) == i);
      hit_m = (int'(id_m) == i);
      wen   = hit_e | hit_m;
      d     = hit_m ? val_m : val_e;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= d;
    end
    assign rf[i] = q;
  end

  always_comb begin
    rd_a = (int'(id_a) < NREG) ? rf[id_a] : '0;
    rd_b = (int'(id_b) < NREG) ? rf[id_b] : '0;
  end

  p_write_e_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_e != ID_NONE && id_e != id_m) |=> rf[$past(id_e)] == $past(val_e));

  p_prio_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_m != ID_NONE) |=> rf[$past(id_m)] == $past(val_m));
endmodule

// File: rtl/regsel_top.sv
module regsel_top
  import regsel_pkg::*;
#(
  parameter int              XLEN  = 64,
  parameter int              NREG  = 15,
  parameter logic [ID_W-1:0] SP_ID = 4'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      icode,
  input  logic [ID_W-1:0] ra,
  input  logic [ID_W-1:0] rb,
  input  logic            cnd,
  input  logic [XLEN-1:0] val_e,
  input  logic [XLEN-1:0] val_m,
  output logic [ID_W-1:0] src_a,
  output logic [ID_W-1:0] src_b,
  output logic [ID_W-1:0] dst_e,
  output logic [ID_W-1:0] dst_m,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  regids_t ids;
  logic    rst_sync_n;

  regsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  regsel_id_decode #(.SP_ID(SP_ID)) u_dec (
    .icode(icode), .ra(ra), .rb(rb), .cnd(cnd), .ids(ids));

  regsel_bank #(.XLEN(XLEN), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .id_a(ids.src_a), .id_b(ids.src_b), .id_e(ids.dst_e), .id_m(ids.dst_m),
    .val_e(val_e), .val_m(val_m), .rd_a(rd_a), .rd_b(rd_b));

  assign src_a = ids.src_a;
  assign src_b = ids.src_b;
  assign dst_e = ids.dst_e;
  assign dst_m = ids.dst_m;

  p_cmov_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == OP_MOVC && !cnd) |-> (dst_e == ID_NONE && src_b == ID_NONE));

  p_stack_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == OP_POP) |-> (src_a == SP_ID && src_b == SP_ID && dst_e == SP_ID));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == OP_HALT || icode == OP_NOP || icode == OP_JUMP || icode >= 4'hC)
    |-> (src_a & src_b & dst_e & dst_m) == ID_NONE);

  p_null_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == ID_NONE && src_b == ID_NONE) |-> (rd_a == '0 && rd_b == '0));
endmodule

// File: tb/tb_regsel_top.sv
module tb_regsel_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  icode, ra, rb;
  logic        cnd;
  logic [63:0] val_e, val_m;
  logic [3:0]  src_a, src_b, dst_e, dst_m;
  logic [63:0] rd_a, rd_b;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  regsel_top dut (.*);

  // {icode, ra, rb, cnd, src_a, src_b, dst_e, dst_m}
  localparam logic [28:0] VEC [16] = '{
    {4'h6, 4'h1, 4'h2, 1'b0, 4'h1, 4'h2, 4'h2, 4'hF},
    {4'h6, 4'h1, 4'h2, 1'b1, 4'h1, 4'h2, 4'h2, 4'hF},
    {4'h4, 4'h3, 4'h5, 1'b1, 4'h3, 4'h5, 4'hF, 4'hF},
    {4'h5, 4'h7, 4'h8, 1'b0, 4'hF, 4'h8, 4'hF, 4'h7},
    {4'h3, 4'hF, 4'h9, 1'b0, 4'hF, 4'hF, 4'h9, 4'hF},
    {4'h2, 4'h1, 4'hA, 1'b1, 4'h1, 4'hF, 4'hA, 4'hF},
    {4'h2, 4'h1, 4'hA, 1'b0, 4'h1, 4'hF, 4'hF, 4'hF},
    {4'h8, 4'hF, 4'hF, 1'b1, 4'hF, 4'h4, 4'h4, 4'hF},
    {4'h9, 4'hF, 4'hF, 1'b0, 4'h4, 4'h4, 4'h4, 4'hF},
    {4'hA, 4'h6, 4'hF, 1'b0, 4'h6, 4'h4, 4'h4, 4'hF},
    {4'hB, 4'h6, 4'hF, 1'b1, 4'h4, 4'h4, 4'h4, 4'h6},
    {4'h0, 4'h1, 4'h2, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF},
    {4'h1, 4'h1, 4'h2, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF},
    {4'h7, 4'h3, 4'h3, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF},
    {4'hC, 4'h1, 4'h2, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF},
    {4'hF, 4'h1, 4'h2, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF}
  };

  function automatic string tag_of(input logic [3:0] c, input logic k);
    case (c)
      4'h2: return "R4";
      4'h3, 4'h4, 4'h5, 4'h6: return k ? "R2 R9" : "R2";
      4'h8, 4'h9, 4'hA, 4'hB: return k ? "R3 R9" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [3:0] a, input logic [3:0] b,
                       input logic k, input logic [63:0] e, input logic [63:0] m);
    @(negedge clk);
    icode = c; ra = a; rb = b; cnd = k; val_e = e; val_m = m;
    #1;
  endtask

  // Store class reads ra on rd_a without writing anything.
  task automatic rd_chk(input string tag, input logic [3:0] id, input logic [63:0] exp);
    drive(4'h4, id, id, 1'b0, 64'h0, 64'h0);
    chk(tag, rd_a, exp);
  endtask

  initial begin
    rst_n = 1'b0; icode = 4'h1; ra = 4'h0; rb = 4'h0; cnd = 1'b0;
    val_e = '0; val_m = '0;
    #1;
    rd_chk("R1 during reset", 4'h2, 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 15; i++) rd_chk("R1 after reset", 4'(i), 64'h0);

    for (int v = 0; v < 16; v++) begin
      drive(VEC[v][28:25], VEC[v][24:21], VEC[v][20:17], VEC[v][16], 64'h0, 64'h0);
      chk(tag_of(VEC[v][28:25], VEC[v][16]),
          {48'h0, src_a, src_b, dst_e, dst_m}, {48'h0, VEC[v][15:0]});
    end

    drive(4'h6, 4'h1, 4'h2, 1'b1, 64'h1111_2222_3333_4444, 64'h55);
    rd_chk("R7 ALU write to rb", 4'h2, 64'h1111_2222_3333_4444);
    drive(4'h5, 4'h3, 4'h0, 1'b0, 64'h77, 64'hABCD_0000_0000_1234);
    rd_chk("R7 load write to ra", 4'h3, 64'hABCD_0000_0000_1234);
    rd_chk("R7 null dst untouched", 4'h0, 64'h0);
    drive(4'hB, 4'h5, 4'h0, 1'b0, 64'h0000_0000_0000_1008, 64'hDEAD_BEEF);
    rd_chk("R3 pop sp from ALU", 4'h4, 64'h0000_0000_0000_1008);
    rd_chk("R3 pop ra from memory", 4'h5, 64'hDEAD_BEEF);
    drive(4'hB, 4'h4, 4'h0, 1'b0, 64'h2222, 64'h9999);
    rd_chk("R8 memory result wins", 4'h4, 64'h9999);
    drive(4'h2, 4'h1, 4'h6, 1'b0, 64'hCAFE, 64'h0);
    rd_chk("R4 cancelled move", 4'h6, 64'h0);
    drive(4'h2, 4'h1, 4'h6, 1'b1, 64'hCAFE, 64'h0);
    rd_chk("R4 taken move", 4'h6, 64'hCAFE);
    drive(4'h7, 4'h2, 4'h2, 1'b1, 64'h1, 64'h2);
    rd_chk("R5 jump writes nothing", 4'h2, 64'h1111_2222_3333_4444);
    drive(4'h2, 4'h2, 4'h0, 1'b0, 64'h0, 64'h0);
    chk("R6 null src_b reads zero", rd_b, 64'h0);
    chk("R6 move reads ra", rd_a, 64'h1111_2222_3333_4444);
    drive(4'h4, 4'hF, 4'h4, 1'b0, 64'h0, 64'h0);
    chk("R6 null src_a reads zero", rd_a, 64'h0);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_chk("R1 async clear", 4'h2, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R1 cleared after release", 4'h6, 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule